// File: doc/BRIEF.md
# Reflected Power Mismatch Governor

This block sits between the reflected-power sensing chain and the power controller of an RF or microwave energy delivery path. Each accepted sample carries a digitized reflected-power level, a forward-power level and a flag that reports a steep temperature slope. From these samples the block produces five things: a power ceiling, a ramp-freeze control, a pulsed-delivery request with its on/off drive window, and a trip request. A reason code reports why the current action holds.

A reflected-power step past the engage level freezes the ramp at once and clamps the ceiling to a programmed derate value. The clamp releases only after a programmed number of consecutive samples lie below a lower release level. A reflected level past the severe limit raises the trip request in the same cycle and latches the block safe until an external clear arrives. If the temperature slope stays high while the block is clamped, delivery changes to on windows separated by cooldown gaps.

Samples arrive on a valid/ready stream. The block never applies back-pressure: `s_ready` is always high, every cycle with `s_valid` high consumes one sample, and cycles with `s_valid` low change no state. All lengths are counted in accepted samples. Thresholds, lengths and ceilings are plain configuration inputs and are held steady by the system.

Top module: `mismatch_governor`

## Requirements
- R1: After reset the block reports the normal state: ceiling equals `cfg_full_ceil`, freeze low, pulse mode low, drive window high, trip low, forward-over low, reason 0.
- R2: In the normal state, an accepted sample with reflected level at or above `cfg_thr_assert` (and below severe) enters the clamped state on that clock edge: freeze goes high, the ceiling becomes `cfg_derate_ceil`, and the reason becomes 1 (high mismatch).
- R3: The clamp releases to normal only when `cfg_hold_ticks` consecutive accepted samples (0 is taken as 1) have reflected level below `cfg_thr_release`. Any accepted sample at or above the release level restarts the count. The sample that caused the clamp does not count.
- R4: Hysteresis: a sample whose level lies between the release and engage levels neither engages the clamp in the normal state nor counts as quiet while clamped.
- R5: An accepted sample at or above `cfg_thr_severe` drives `trip_req_o` high in the same cycle, from any state, with no filtering. The block then latches the tripped state: ceiling 0, freeze high, drive window low, trip high, reason 3.
- R6: `clr_trip` leaves the tripped state for the clamped state with a fresh hold count (reason 1). A clear that coincides with a severe sample does not release the trip. Outside the tripped state, `clr_trip` has no effect.
- R7: While clamped, `cfg_slope_ticks` consecutive accepted samples (0 taken as 1) with `s_tslope_hi` high switch the block to pulsed delivery: pulse mode high, ceiling still the derate value, reason 2.
- R8: In pulsed delivery the drive window is high for `cfg_on_ticks` accepted samples (0 taken as 1) and then low for `cfg_gap_ticks` accepted samples, repeating. It starts high on entry. A gap of 0 keeps it high. The hold qualifier keeps running, and its completion returns the block to normal.
- R9: `s_ready` is always high, and a cycle with `s_valid` low changes no output except through `clr_trip`.
- R10: `fwd_over_o` is registered on each accepted sample. It is high when the sample's forward level exceeds the ceiling in force when the sample is taken.
- R11: Priority on one sample: severe trip first, then hold completion (return to normal), then slope persistence (pulsed).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample ready, constant high |
| s_refl | input | PW_W | Reflected power level |
| s_fwd | input | PW_W | Forward power level |
| s_tslope_hi | input | 1 | Temperature slope above limit |
| clr_trip | input | 1 | Deliberate trip clear |
| cfg_thr_assert | input | PW_W | Clamp engage level |
| cfg_thr_release | input | PW_W | Quiet level (below means quiet) |
| cfg_thr_severe | input | PW_W | Immediate trip level |
| cfg_hold_ticks | input | CNT_W | Quiet samples needed to release |
| cfg_slope_ticks | input | CNT_W | Slope samples needed to pulse |
| cfg_full_ceil | input | PW_W | Ceiling in normal state |
| cfg_derate_ceil | input | PW_W | Ceiling while clamped or pulsed |
| cfg_on_ticks | input | WIN_W | Pulsed on-window length |
| cfg_gap_ticks | input | WIN_W | Pulsed cooldown-gap length |
| ceiling_o | output | PW_W | Power ceiling for the controller |
| ramp_freeze_o | output | 1 | Ramp-up frozen |
| pulse_mode_o | output | 1 | Pulsed delivery active |
| drive_window_o | output | 1 | Delivery permitted this interval |
| trip_req_o | output | 1 | Trip request |
| fwd_over_o | output | 1 | Last forward sample above ceiling |
| reason_o | output | 2 | 0 none, 1 high mismatch, 2 thermal pulsed, 3 severe trip |

## Verification
The bench builds the block with PW_W=8, CNT_W=6 and WIN_W=4. The narrow level width lets random reflected samples fall in every band around the three levels often, including exact equality with each one. The short count widths let random hold, slope, on and gap settings include the zero-means-one cases and lengths of a few samples, so many complete release, pulse and trip cycles fit in a short run. Directed sequences cover dips shorter than the hold, a restart from a mid-band sample, simultaneous release and slope completion, and a clear applied with a severe sample.

// File: rtl/mg_pkg.sv
package mg_pkg;
  typedef enum logic [1:0] {
    GS_NORMAL  = 2'd0,
    GS_DERATE  = 2'd1,
    GS_PULSED  = 2'd2,
    GS_TRIPPED = 2'd3
  } gov_state_e;

  typedef enum logic [1:0] {
    RC_NONE     = 2'd0,
    RC_MISMATCH = 2'd1,
    RC_THERMAL  = 2'd2,
    RC_SEVERE   = 2'd3
  } reason_e;

  function automatic reason_e reason_of(gov_state_e st);
    case (st)
      GS_DERATE:  return RC_MISMATCH;
      GS_PULSED:  return RC_THERMAL;
      GS_TRIPPED: return RC_SEVERE;
      default:    return RC_NONE;
    endcase
  endfunction
endpackage

// File: rtl/mg_level_cmp.sv
module mg_level_cmp #(
  parameter int PW_W = 12
) (
  input  logic [PW_W-1:0] level,
  input  logic [PW_W-1:0] thr_assert,
  input  logic [PW_W-1:0] thr_release,
  input  logic [PW_W-1:0] thr_severe,
  output logic            hit_assert,
  output logic            hit_severe,
  output logic            quiet
);
  // Three independent magnitude compares; no filtering on any of them.
  always_comb begin
    hit_assert = (level >= thr_assert);
    hit_severe = (level >= thr_severe);
    quiet      = (level <  thr_release);
  end
endmodule

// File: rtl/mg_run_counter.sv
module mg_run_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic             cond,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W:0]   ONE     = {{CNT_W{1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   lim_eff;
  logic [CNT_W:0]   run_len;

  // A zero limit behaves as one sample.
  assign lim_eff = (limit == '0) ? ONE : {1'b0, limit};
  assign run_len = {1'b0, cnt_q} + ONE;
  assign done    = !clear && step && cond && (run_len >= lim_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (step) begin
      if (!cond)                cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3: a broken run leaves no credit for the next sample.
  assert_run_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cond && !clear) |=> (run_len == ONE));
endmodule

// File: rtl/mg_pulse_gen.sv
module mg_pulse_gen #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  input  logic [WIN_W-1:0] on_len,
  input  logic [WIN_W-1:0] gap_len,
  output logic             window_o
);
  localparam logic [WIN_W:0] ONE = {{WIN_W{1'b0}}, 1'b1};

  logic             phase_on_q;
  logic [WIN_W-1:0] cnt_q;
  logic [WIN_W:0]   seg_len;
  logic [WIN_W:0]   on_eff;
  logic             seg_end;

  assign on_eff  = (on_len == '0) ? ONE : {1'b0, on_len};
  assign seg_len = {1'b0, cnt_q} + ONE;
  assign seg_end = phase_on_q ? (seg_len >= on_eff) : (seg_len >= {1'b0, gap_len});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_on_q <= 1'b1;
      cnt_q      <= '0;
    end else if (!run) begin
      phase_on_q <= 1'b1;
      cnt_q      <= '0;
    end else if (step) begin
      if (seg_end) begin
        cnt_q      <= '0;
        phase_on_q <= phase_on_q ? (gap_len == '0) : 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign window_o = phase_on_q;

  // R8: with no cooldown gap the window never closes.
  assert_no_gap_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_len == '0 && $stable(gap_len) && window_o) |=> window_o);
  // R8: a pulsed episode always opens with the window high.
  assert_entry_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> window_o);
endmodule

// File: rtl/mismatch_governor.sv
module mismatch_governor
  import mg_pkg::*;
#(
  parameter int PW_W  = 12,
  parameter int CNT_W = 16,
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [PW_W-1:0]  s_refl,
  input  logic [PW_W-1:0]  s_fwd,
  input  logic             s_tslope_hi,
  input  logic             clr_trip,
  input  logic [PW_W-1:0]  cfg_thr_assert,
  input  logic [PW_W-1:0]  cfg_thr_release,
  input  logic [PW_W-1:0]  cfg_thr_severe,
  input  logic [CNT_W-1:0] cfg_hold_ticks,
  input  logic [CNT_W-1:0] cfg_slope_ticks,
  input  logic [PW_W-1:0]  cfg_full_ceil,
  input  logic [PW_W-1:0]  cfg_derate_ceil,
  input  logic [WIN_W-1:0] cfg_on_ticks,
  input  logic [WIN_W-1:0] cfg_gap_ticks,
  output logic [PW_W-1:0]  ceiling_o,
  output logic             ramp_freeze_o,
  output logic             pulse_mode_o,
  output logic             drive_window_o,
  output logic             trip_req_o,
  output logic             fwd_over_o,
  output logic [1:0]       reason_o
);
  gov_state_e state_q, state_d;
  logic       hit_assert, hit_severe, quiet;
  logic       hold_done, slope_done, pulse_window;
  logic       hold_clear, slope_clear;
  logic       fwd_over_q;
  logic       sev_now;

  // The stream never stalls: one sample per cycle.
  assign s_ready = 1'b1;

  mg_level_cmp #(.PW_W(PW_W)) u_cmp (
    .level       (s_refl),
    .thr_assert  (cfg_thr_assert),
    .thr_release (cfg_thr_release),
    .thr_severe  (cfg_thr_severe),
    .hit_assert  (hit_assert),
    .hit_severe  (hit_severe),
    .quiet       (quiet)
  );

  assign hold_clear  = (state_q == GS_NORMAL) || (state_q == GS_TRIPPED);
  assign slope_clear = (state_q != GS_DERATE);

  mg_run_counter #(.CNT_W(CNT_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (hold_clear),
    .step  (s_valid),
    .cond  (quiet),
    .limit (cfg_hold_ticks),
    .done  (hold_done)
  );

  mg_run_counter #(.CNT_W(CNT_W)) u_slope (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (slope_clear),
    .step  (s_valid),
    .cond  (s_tslope_hi),
    .limit (cfg_slope_ticks),
    .done  (slope_done)
  );

  mg_pulse_gen #(.WIN_W(WIN_W)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (state_q == GS_PULSED),
    .step     (s_valid),
    .on_len   (cfg_on_ticks),
    .gap_len  (cfg_gap_ticks),
    .window_o (pulse_window)
  );

  assign sev_now = s_valid && hit_severe;

  // Next state: severe trip outranks release, release outranks pulsing.
  always_comb begin
    state_d = state_q;
    if (sev_now) begin
      state_d = GS_TRIPPED;
    end else begin
      case (state_q)
        GS_NORMAL:  if (s_valid && hit_assert) state_d = GS_DERATE;
        GS_DERATE: begin
          if (hold_done)       state_d = GS_NORMAL;
          else if (slope_done) state_d = GS_PULSED;
        end
        GS_PULSED:  if (hold_done) state_d = GS_NORMAL;
        GS_TRIPPED: if (clr_trip)  state_d = GS_DERATE;
        default:    state_d = GS_TRIPPED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= GS_NORMAL;
      fwd_over_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (s_valid) fwd_over_q <= (s_fwd > ceiling_o);
    end
  end

  always_comb begin
    case (state_q)
      GS_NORMAL:  ceiling_o = cfg_full_ceil;
      GS_TRIPPED: ceiling_o = '0;
      default:    ceiling_o = cfg_derate_ceil;
    endcase
  end

  assign ramp_freeze_o  = (state_q != GS_NORMAL);
  assign pulse_mode_o   = (state_q == GS_PULSED);
  assign drive_window_o = (state_q == GS_PULSED) ? pulse_window : (state_q != GS_TRIPPED);
  assign trip_req_o     = (state_q == GS_TRIPPED) || sev_now;
  assign fwd_over_o     = fwd_over_q;
  assign reason_o       = reason_of(state_q);

  // R2: the clamp engages only from an accepted sample at the engage level.
  assert_engage_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == GS_DERATE && $past(state_q) == GS_NORMAL)
      |-> $past(s_valid && s_refl >= cfg_thr_assert));
  // R3: release to normal always follows an accepted quiet sample.
  assert_release_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == GS_NORMAL && $past(state_q) != GS_NORMAL)
      |-> $past(s_valid && s_refl < cfg_thr_release));
  // R5: the trip latch only opens with a clear.
  assert_trip_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == GS_TRIPPED && !clr_trip) |=> (state_q == GS_TRIPPED));
  // R5: entering the trip needs a severe sample.
  assert_trip_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == GS_TRIPPED) |-> $past(s_valid && s_refl >= cfg_thr_severe));
  // R7: pulsed delivery is entered from the clamp with the slope flag high.
  assert_pulse_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == GS_PULSED && $past(state_q) != GS_PULSED)
      |-> $past(state_q == GS_DERATE && s_tslope_hi));
  // R9: an empty cycle without a clear leaves the state alone.
  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_valid && !clr_trip) |=> $stable(state_q));
endmodule

// File: tb/tb_mismatch_governor.sv
module tb_mismatch_governor;
  localparam int CLK_PERIOD = 10;
  localparam int PW_W  = 8;
  localparam int CNT_W = 6;
  localparam int WIN_W = 4;
  localparam int ST_N = 0, ST_D = 1, ST_P = 2, ST_T = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic             b_valid = 1'b0, b_slope = 1'b0, b_clr = 1'b0;
  logic [PW_W-1:0]  b_refl = '0, b_fwd = '0;
  logic [PW_W-1:0]  c_as = '0, c_rel = '0, c_sev = '0, c_full = '0, c_der = '0;
  logic [CNT_W-1:0] c_hold = '0, c_slope = '0;
  logic [WIN_W-1:0] c_on = '0, c_gap = '0;

  logic             s_ready, ramp_freeze_o, pulse_mode_o, drive_window_o, trip_req_o, fwd_over_o;
  logic [PW_W-1:0]  ceiling_o;
  logic [1:0]       reason_o;

  mismatch_governor #(.PW_W(PW_W), .CNT_W(CNT_W), .WIN_W(WIN_W)) dut (
    .clk(clk), .rst_n(rst_n), .s_valid(b_valid), .s_ready(s_ready),
    .s_refl(b_refl), .s_fwd(b_fwd), .s_tslope_hi(b_slope), .clr_trip(b_clr),
    .cfg_thr_assert(c_as), .cfg_thr_release(c_rel), .cfg_thr_severe(c_sev),
    .cfg_hold_ticks(c_hold), .cfg_slope_ticks(c_slope),
    .cfg_full_ceil(c_full), .cfg_derate_ceil(c_der),
    .cfg_on_ticks(c_on), .cfg_gap_ticks(c_gap),
    .ceiling_o(ceiling_o), .ramp_freeze_o(ramp_freeze_o), .pulse_mode_o(pulse_mode_o),
    .drive_window_o(drive_window_o), .trip_req_o(trip_req_o), .fwd_over_o(fwd_over_o),
    .reason_o(reason_o)
  );

  int    n_checks = 0, n_fails = 0;
  string cur_req = "R1";

  // Reference model, built from the requirement text.
  int m_state, m_hold, m_sl, m_pcnt;
  bit m_phase, m_fov;

  function automatic int eff1(int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int ceil_of(int st);
    if (st == ST_N) return int'(c_full);
    if (st == ST_T) return 0;
    return int'(c_der);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int ns, nh, nsl, npc, r;
    bit nph, quiet, hdone, sdone;
    if (!rst_n) begin
      m_state = ST_N; m_hold = 0; m_sl = 0; m_pcnt = 0; m_phase = 1; m_fov = 0;
    end else begin
      r = int'(b_refl);
      quiet = r < int'(c_rel);
      hdone = b_valid && quiet && (m_state == ST_D || m_state == ST_P)
              && (m_hold + 1 >= eff1(int'(c_hold)));
      sdone = b_valid && b_slope && m_state == ST_D && (m_sl + 1 >= eff1(int'(c_slope)));
      nh = m_hold; nsl = m_sl;
      if (m_state == ST_N || m_state == ST_T) nh = 0;
      else if (b_valid) nh = quiet ? m_hold + 1 : 0;
      if (m_state != ST_D) nsl = 0;
      else if (b_valid) nsl = b_slope ? m_sl + 1 : 0;
      ns = m_state;
      if (b_valid && r >= int'(c_sev)) ns = ST_T;
      else if (m_state == ST_N && b_valid && r >= int'(c_as)) ns = ST_D;
      else if (m_state == ST_D && hdone) ns = ST_N;
      else if (m_state == ST_D && sdone) ns = ST_P;
      else if (m_state == ST_P && hdone) ns = ST_N;
      else if (m_state == ST_T && b_clr) ns = ST_D;
      nph = m_phase; npc = m_pcnt;
      if (m_state != ST_P) begin nph = 1; npc = 0; end
      else if (b_valid) begin
        if (m_phase) begin
          if (m_pcnt + 1 >= eff1(int'(c_on))) begin npc = 0; nph = (c_gap == 0); end
          else npc = m_pcnt + 1;
        end else begin
          if (m_pcnt + 1 >= int'(c_gap)) begin npc = 0; nph = 1; end
          else npc = m_pcnt + 1;
        end
      end
      if (b_valid) m_fov = int'(b_fwd) > ceil_of(m_state);
      m_state = ns; m_hold = nh; m_sl = nsl; m_phase = nph; m_pcnt = npc;
    end
  end

  task automatic chk(string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic check_regs();
    chk("ceiling", int'(ceiling_o), ceil_of(m_state));
    chk("freeze", int'(ramp_freeze_o), int'(m_state != ST_N));
    chk("pulse_mode", int'(pulse_mode_o), int'(m_state == ST_P));
    chk("window", int'(drive_window_o), (m_state == ST_P) ? int'(m_phase) : int'(m_state != ST_T));
    chk("reason", int'(reason_o), m_state);
    chk("fwd_over", int'(fwd_over_o), int'(m_fov));
    chk("ready", int'(s_ready), 1);
  endtask

  task automatic step(bit v, int r, int f, bit sl, bit cl);
    @(negedge clk);
    check_regs();
    b_valid = v; b_refl = PW_W'(r); b_fwd = PW_W'(f); b_slope = sl; b_clr = cl;
    #1;
    chk("trip", int'(trip_req_o), int'(m_state == ST_T || (v && r >= int'(c_sev))));
  endtask

  task automatic set_cfg(int rel, int as, int sev, int hold, int slp, int full, int der, int on, int gap);
    c_rel = PW_W'(rel); c_as = PW_W'(as); c_sev = PW_W'(sev);
    c_hold = CNT_W'(hold); c_slope = CNT_W'(slp);
    c_full = PW_W'(full); c_der = PW_W'(der);
    c_on = WIN_W'(on); c_gap = WIN_W'(gap);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    int rr, bucket;
    bit sl;
    void'($urandom(32'h5EED_0A1B));
    set_cfg(60, 100, 200, 4, 3, 250, 120, 2, 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    cur_req = "R1";
    step(0, 0, 0, 0, 0);
    // R4: mid-band samples do not engage
    cur_req = "R4";
    repeat (3) step(1, 80, 240, 0, 0);
    step(1, 99, 100, 0, 0);
    // R2: engage at exactly the assert level
    cur_req = "R2";
    step(1, 100, 130, 0, 0);
    step(1, 50, 130, 0, 0);
    // R3: dips shorter than the hold, restart by a mid-band sample
    cur_req = "R3";
    step(1, 50, 0, 0, 0);
    step(1, 60, 0, 0, 0);
    repeat (3) step(1, 10, 0, 0, 0);
    step(1, 59, 0, 0, 0);
    step(1, 10, 0, 0, 0);
    // R9: idle cycles carry no effect
    cur_req = "R9";
    step(1, 150, 0, 0, 0);
    repeat (4) step(0, 255, 255, 1, 0);
    // R7: slope persistence to pulsed
    cur_req = "R7";
    step(1, 80, 0, 1, 0);
    step(1, 80, 0, 0, 0);
    repeat (3) step(1, 80, 0, 1, 0);
    // R8: pulse windows
    cur_req = "R8";
    repeat (12) step(1, 80, 200, 1, 0);
    repeat (3) step(0, 80, 0, 0, 0);
    repeat (4) step(1, 20, 0, 0, 0);
    // R6: clear outside trip ignored
    cur_req = "R6";
    step(1, 20, 0, 0, 1);
    // R5: severe trip, immediate
    cur_req = "R5";
    step(1, 200, 0, 0, 0);
    repeat (3) step(1, 10, 0, 0, 0);
    // R6: clear with a severe sample holds, then clear releases
    cur_req = "R6";
    step(1, 230, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    repeat (5) step(1, 10, 0, 0, 0);
    // R11: release beats slope on the same sample
    cur_req = "R11";
    set_cfg(60, 100, 200, 1, 1, 250, 120, 0, 0);
    step(1, 120, 0, 0, 0);
    step(1, 10, 0, 1, 0);
    step(1, 120, 0, 0, 0);
    step(1, 80, 0, 1, 0);
    // R8: zero on length and zero gap keep the window open
    cur_req = "R8";
    repeat (4) step(1, 80, 0, 0, 0);
    // R10: forward level against the ceiling in force
    cur_req = "R10";
    step(1, 10, 121, 0, 0);
    step(1, 10, 251, 0, 0);
    step(1, 10, 250, 0, 0);
    // Random phase
    cur_req = "R3";
    sl = 0;
    for (int blk = 0; blk < 8; blk++) begin
      set_cfg(40 + $urandom_range(39), 100 + $urandom_range(39), 200 + $urandom_range(39),
              $urandom_range(6), $urandom_range(4), 200 + $urandom_range(55),
              50 + $urandom_range(99), $urandom_range(3), $urandom_range(3));
      for (int i = 0; i < 500; i++) begin
        bucket = $urandom_range(99);
        if (bucket < 50)      rr = $urandom_range(int'(c_rel) - 1);
        else if (bucket < 80) rr = $urandom_range(int'(c_as) - 1, int'(c_rel));
        else if (bucket < 97) rr = $urandom_range(int'(c_sev) - 1, int'(c_as));
        else                  rr = $urandom_range(255, int'(c_sev));
        if ($urandom_range(5) == 0) sl = !sl;
        step($urandom_range(9) < 8, rr, $urandom_range(255), sl, $urandom_range(49) == 0);
      end
    end
    step(0, 0, 0, 0, 0);
    summary();
    $finish;
  end
endmodule